// File: doc/BRIEF.md
# Line Transceiver Enable and Protection Control

This block is the digital control core of a differential line transceiver. It decides, each cycle, whether the two complementary driver legs are enabled and which levels they carry, and whether the receiver output is enabled and which level it reports. Its inputs are the transmit bit, an active-high driver enable, an active-low receiver enable, power-good flags for the logic side and the bus side, an 8-bit die temperature code, and a 2-bit classification of the receiver's differential input voltage.

A registered thermal guard with hysteresis turns the driver off while the die is hot. A receiver decision stage turns the input class into a logic level. An idle or open line reads as high, and a differential voltage inside the undecided band repeats the last decided level. When a supply is missing, the affected outputs fall to a defined state. Any output whose enable is low is driven to 0, so the surrounding pad logic sees a known value.

Top module: `xcvr_ctrl`

## Requirements
- R1: During and after a synchronous reset (`rst_n` low at a clock edge), the thermal shutdown is clear and the held receiver level is 1. In the first cycle after reset, a band-class input therefore reads 1 and an enabled driver is active.
- R2: With both power flags high, `drv_en` high and no thermal shutdown, `out_p` equals `tx_data` and `out_n` equals its complement, with `out_p_oe` and `out_n_oe` both 1.
- R3: With `drv_en` low or `bus_pwr_ok` low, both driver enables are 0 and both driver values are 0.
- R4: With `rcv_en_n` high, `rx_oe` is 0 and `rx_data` is 0.
- R5: With the bus side powered and the receiver enabled, `rx_data` follows the line class with no added cycle. Class 2'b00 (above the upper threshold) gives 1, class 2'b01 (below the lower threshold) gives 0, and class 2'b11 (open inputs) gives 1.
- R6: Class 2'b10 (between the thresholds) repeats the level decided in the previous cycle. That level is itself 1 after reset or after the bus side was unpowered.
- R7: A `die_temp` of 150 or more sampled at a clock edge disables the driver from that edge onward.
- R8: After a shutdown, a `die_temp` of 140 or less sampled at an edge re-enables the driver. Values from 141 to 149 leave the shutdown state unchanged in either direction.
- R9: With `bus_pwr_ok` low and `logic_pwr_ok` high and the receiver enabled, `rx_data` is 1 and the held level is forced to 1.
- R10: With `logic_pwr_ok` low, all three enables are 0 and all three output values are 0, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 1 | Transmit bit |
| drv_en | input | 1 | Driver enable, active high |
| rcv_en_n | input | 1 | Receiver enable, active low |
| logic_pwr_ok | input | 1 | Logic-side supply present |
| bus_pwr_ok | input | 1 | Bus-side supply present |
| die_temp | input | 8 | Die temperature, unsigned degrees Celsius |
| line_class | input | 2 | Receiver differential input class |
| out_p | output | 1 | Noninverting driver leg value |
| out_n | output | 1 | Inverting driver leg value |
| out_p_oe | output | 1 | Noninverting leg enable |
| out_n_oe | output | 1 | Inverting leg enable |
| rx_data | output | 1 | Receiver output value |
| rx_oe | output | 1 | Receiver output enable |

## Verification
The assertions assume that the inputs are stable across each clock edge and are known (not X) from the first reset edge onward. They also assume that `die_temp` is a plain unsigned code, so the threshold comparisons see no wrap. The bench changes every input only between a rising edge and the following falling edge, and it holds reset low for several edges before the first check. It sweeps every combination of enables, supply flags and transmit bit under each line class, and it walks the temperature across both trip points from above and below.

// File: rtl/xcvr_ctrl_pkg.sv
// Shared types for the transceiver control block.
// Assumes the line class code is produced by an external comparator pair.
package xcvr_ctrl_pkg;

    // Receiver differential input classes
    typedef enum logic [1:0] {
        LC_ABOVE = 2'b00,
        LC_BELOW = 2'b01,
        LC_BAND  = 2'b10,
        LC_OPEN  = 2'b11
    } line_class_e;

endpackage

// File: rtl/xcvr_thermal_guard.sv
// Registered thermal shutdown with hysteresis.
// Sets when temp >= TRIP_HI and clears when temp <= TRIP_LO; in between, the state is kept.
// Assumes TRIP_LO < TRIP_HI, both representable in TEMP_W bits.
module xcvr_thermal_guard #(
    parameter int TEMP_W  = 8,
    parameter int TRIP_HI = 150,
    parameter int TRIP_LO = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              shutdown
);
    localparam logic [TEMP_W-1:0] HI_CODE = TEMP_W'(TRIP_HI);
    localparam logic [TEMP_W-1:0] LO_CODE = TEMP_W'(TRIP_LO);

    logic over_hi;
    logic under_lo;

    // Threshold comparisons
    always_comb begin
        over_hi  = (temp >= HI_CODE);
        under_lo = (temp <= LO_CODE);
    end

    // Hysteretic shutdown state
    always_ff @(posedge clk) begin
        if (!rst_n)         shutdown <= 1'b0;
        else if (over_hi)   shutdown <= 1'b1;
        else if (under_lo)  shutdown <= 1'b0;
    end

    AST_TRIP_SETS:  assert property (@(posedge clk) disable iff (!rst_n)
        (temp >= HI_CODE) |=> shutdown);                                  // R7
    AST_COOL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (temp <= LO_CODE) |=> !shutdown);                                 // R8
    AST_BAND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (temp > LO_CODE && temp < HI_CODE) |=> $stable(shutdown));        // R8
endmodule

// File: rtl/xcvr_driver_stage.sv
// Complementary driver legs with a shared enable.
// Leg k carries tx ^ k when active; disabled legs are driven to 0.
// Assumes the shutdown input is already registered.
module xcvr_driver_stage #(
    parameter int LEGS = 2
) (
    input  logic            logic_ok,
    input  logic            bus_ok,
    input  logic            en,
    input  logic            shutdown,
    input  logic            tx,
    output logic [LEGS-1:0] leg_val,
    output logic [LEGS-1:0] leg_oe
);
    logic active;

    // Driver is active only with both supplies, enable and a cool die
    always_comb active = logic_ok && bus_ok && en && !shutdown;

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        localparam logic POL = logic'(k % 2);
        // Per-leg value and enable
        always_comb begin
            leg_oe[k]  = active;
            leg_val[k] = active && (tx ^ POL);
        end
    end
endmodule

// File: rtl/xcvr_receiver_stage.sv
// Fail-safe receiver decision with band hold.
// Above/open give 1, below gives 0, band repeats the last decided level.
// A missing bus supply forces the level and the held state to 1.
module xcvr_receiver_stage
    import xcvr_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        logic_ok,
    input  logic        bus_ok,
    input  logic        en_n,
    input  line_class_e cls,
    output logic        rx_val,
    output logic        rx_oe
);
    logic held;
    logic level;

    // Decide the receiver level from the current class
    always_comb begin
        if (!bus_ok) level = 1'b1;
        else begin
            unique case (cls)
                LC_ABOVE: level = 1'b1;
                LC_BELOW: level = 1'b0;
                LC_BAND:  level = held;
                LC_OPEN:  level = 1'b1;
                default:  level = 1'b1;
            endcase
        end
    end

    // Remember the last decided level for the band class
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b1;
        else        held <= level;
    end

    // Output enable and gated value
    always_comb begin
        rx_oe  = logic_ok && !en_n;
        rx_val = rx_oe && level;
    end

    AST_BAND_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_ok) && $past(cls) == LC_BELOW
         && bus_ok && cls == LC_BAND && rx_oe) |-> !rx_val);             // R6
    AST_BUS_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ok && rx_oe) |-> rx_val);                                   // R9
endmodule

// File: rtl/xcvr_ctrl.sv
// Top of the transceiver enable and protection control.
// Combines the thermal guard, the complementary driver legs and the receiver decision.
// Assumes inputs are synchronous to clk.
module xcvr_ctrl
    import xcvr_ctrl_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int TRIP_HI = 150,
    parameter int TRIP_LO = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_data,
    input  logic              drv_en,
    input  logic              rcv_en_n,
    input  logic              logic_pwr_ok,
    input  logic              bus_pwr_ok,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [1:0]        line_class,
    output logic              out_p,
    output logic              out_n,
    output logic              out_p_oe,
    output logic              out_n_oe,
    output logic              rx_data,
    output logic              rx_oe
);
    localparam int LEGS = 2;

    logic            hot;
    logic [LEGS-1:0] leg_val;
    logic [LEGS-1:0] leg_oe;
    line_class_e     cls;

    // Interpret the raw class code
    always_comb cls = line_class_e'(line_class);

    xcvr_thermal_guard #(
        .TEMP_W (TEMP_W),
        .TRIP_HI(TRIP_HI),
        .TRIP_LO(TRIP_LO)
    ) u_thermal (
        .clk     (clk),
        .rst_n   (rst_n),
        .temp    (die_temp),
        .shutdown(hot)
    );

    xcvr_driver_stage #(.LEGS(LEGS)) u_driver (
        .logic_ok(logic_pwr_ok),
        .bus_ok  (bus_pwr_ok),
        .en      (drv_en),
        .shutdown(hot),
        .tx      (tx_data),
        .leg_val (leg_val),
        .leg_oe  (leg_oe)
    );

    xcvr_receiver_stage u_receiver (
        .clk     (clk),
        .rst_n   (rst_n),
        .logic_ok(logic_pwr_ok),
        .bus_ok  (bus_pwr_ok),
        .en_n    (rcv_en_n),
        .cls     (cls),
        .rx_val  (rx_data),
        .rx_oe   (rx_oe)
    );

    // Map legs onto named pins
    always_comb begin
        out_p    = leg_val[0];
        out_n    = leg_val[1];
        out_p_oe = leg_oe[0];
        out_n_oe = leg_oe[1];
    end

    AST_LEGS_OPPOSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_p_oe |-> (out_p != out_n) && (out_p == tx_data));            // R2
    AST_DRV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en || !bus_pwr_ok) |-> !out_p_oe && !out_n_oe && !out_p && !out_n); // R3
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_en_n |-> !rx_oe && !rx_data);                                // R4
    AST_HOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(die_temp) >= TEMP_W'(TRIP_HI)) |-> !out_p_oe && !out_n_oe); // R7
    AST_LOGIC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !logic_pwr_ok |-> !out_p_oe && !out_n_oe && !rx_oe && !out_p && !out_n && !rx_data); // R10
endmodule

// File: tb/sim_xcvr_ctrl.sv
module sim_xcvr_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_data = 1'b0, drv_en = 1'b0, rcv_en_n = 1'b1;
    logic       logic_pwr_ok = 1'b1, bus_pwr_ok = 1'b1;
    logic [7:0] die_temp = 8'd25;
    logic [1:0] line_class = 2'b11;
    logic       out_p, out_n, out_p_oe, out_n_oe, rx_data, rx_oe;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    bit m_valid = 0;
    bit m_hot   = 0;
    bit m_held  = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .drv_en(drv_en),
        .rcv_en_n(rcv_en_n), .logic_pwr_ok(logic_pwr_ok), .bus_pwr_ok(bus_pwr_ok),
        .die_temp(die_temp), .line_class(line_class),
        .out_p(out_p), .out_n(out_n), .out_p_oe(out_p_oe), .out_n_oe(out_n_oe),
        .rx_data(rx_data), .rx_oe(rx_oe)
    );

    function automatic bit rx_level();
        if (!bus_pwr_ok) return 1'b1;
        case (line_class)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return m_held;
            default: return 1'b1;
        endcase
    endfunction

    task automatic compare(string tag);
        bit on, roe;
        logic [3:0] exp_d, got_d;
        logic [1:0] exp_r, got_r;
        on    = logic_pwr_ok && bus_pwr_ok && drv_en && !m_hot;
        exp_d = {on && tx_data, on && !tx_data, on, on};
        got_d = {out_p, out_n, out_p_oe, out_n_oe};
        roe   = logic_pwr_ok && !rcv_en_n;
        exp_r = {roe && rx_level(), roe};
        got_r = {rx_data, rx_oe};
        checks++;
        if (got_d !== exp_d) begin
            errors++;
            $display("FAIL %s driver {p,n,poe,noe} got %b exp %b", tag, got_d, exp_d);
        end
        checks++;
        if (got_r !== exp_r) begin
            errors++;
            $display("FAIL %s receiver {data,oe} got %b exp %b", tag, got_r, exp_r);
        end
    endtask

    // One cycle: check between edges, then advance the model at the edge
    task automatic cyc(string tag);
        @(negedge clk);
        #1;
        if (m_valid) compare(tag);
        @(posedge clk);
        if (!rst_n) begin
            m_hot = 0; m_held = 1; m_valid = 1;
        end else begin
            m_held = rx_level();
            if (die_temp >= 8'd150)      m_hot = 1;
            else if (die_temp <= 8'd140) m_hot = 0;
        end
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drv_en = 1; rcv_en_n = 0; line_class = 2'b10;
        repeat (3) cyc("R1 reset");
        rst_n = 1;
        cyc("R1 band after reset");
        // R2 data following
        for (int i = 0; i < 4; i++) begin
            tx_data = i[0]; line_class = 2'b00;
            cyc("R2");
        end
        // R3 driver gating
        drv_en = 0; tx_data = 1; cyc("R3 drv_en low");
        drv_en = 1; bus_pwr_ok = 0; cyc("R3 bus off");
        bus_pwr_ok = 1;
        // R4 receiver disable
        rcv_en_n = 1; line_class = 2'b00; cyc("R4");
        rcv_en_n = 0;
        // R5 class decode
        line_class = 2'b00; cyc("R5 above");
        line_class = 2'b01; cyc("R5 below");
        line_class = 2'b11; cyc("R5 open");
        // R6 band hold
        line_class = 2'b01; cyc("R6 set low");
        line_class = 2'b10; cyc("R6 hold low");
        cyc("R6 hold low again");
        line_class = 2'b00; cyc("R6 set high");
        line_class = 2'b10; cyc("R6 hold high");
        // R7/R8 thermal hysteresis
        die_temp = 8'd149; cyc("R7 below trip");
        die_temp = 8'd150; cyc("R7 at trip");
        cyc("R7 tripped");
        die_temp = 8'd149; cyc("R8 band keeps hot");
        die_temp = 8'd141; cyc("R8 band keeps hot");
        die_temp = 8'd140; cyc("R8 clear edge");
        cyc("R8 cleared");
        die_temp = 8'd145; cyc("R8 band keeps cool");
        die_temp = 8'd255; cyc("R7 max");
        die_temp = 8'd0;   cyc("R8 min");
        cyc("R8 cool");
        die_temp = 8'd25;
        // R9 bus off receiver
        line_class = 2'b01; cyc("R9 set low");
        bus_pwr_ok = 0; cyc("R9 bus off");
        line_class = 2'b10; cyc("R9 bus off band");
        bus_pwr_ok = 1; cyc("R9 held forced high");
        // R10 logic off
        logic_pwr_ok = 0; line_class = 2'b00; cyc("R10");
        line_class = 2'b01; tx_data = 0; cyc("R10");
        logic_pwr_ok = 1;
        // Truth-table sweep
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 32; v++) begin
                line_class   = 2'(c);
                tx_data      = v[0];
                drv_en       = v[1];
                rcv_en_n     = v[2];
                bus_pwr_ok   = v[3];
                logic_pwr_ok = v[4];
                cyc("SWEEP R2 R3 R4 R5 R6 R9 R10");
            end
        end
        // Sweep under shutdown
        die_temp = 8'd200; logic_pwr_ok = 1; bus_pwr_ok = 1; drv_en = 1;
        for (int v = 0; v < 8; v++) begin
            tx_data = v[0]; line_class = 2'(v >> 1);
            cyc("SWEEP R7 hot");
        end
        // Reset mid-run clears shutdown and hold
        line_class = 2'b01; cyc("R1 pre");
        rst_n = 0; line_class = 2'b10; die_temp = 8'd145; cyc("R1 reset again");
        rst_n = 1; cyc("R1 after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule